// File: doc/BRIEF.md
# PCI Target Retry Timeout Controller

This block is the target-side sequencer of a pass-through bridge between a PCI bus and a simple local interface. It detects the start of an access on the bus and tells the local side through a level that stays high for the whole transaction. It then counts how many clocks the local side takes to become ready for each data phase. When the local side is ready in time, the controller completes the data phase by driving TRDY#. When the local side is too slow, it drives STOP# to ask the initiator to retry or disconnect. The local interface runs on the same clock edge as the bus, so the whole block sits in one clock domain.

The first data phase of a transaction has a 16-clock budget, counted from the edge that samples FRAME# low. Every later phase of a burst has an 8-clock budget. Both budgets are parameters. Writes are posted: the first two write data phases complete without waiting for the local side, so a write can only be disconnected from its third data phase onward. The local side receives a one-cycle pulse after each completed data phase and a one-cycle pulse when a retry or disconnect is issued. The initiator is taken to be ready on every data phase.

Top module: `pci_retry_tmo`

## Requirements
- R1: While reset is held and directly after it, attn is 0, trdy_n and stop_n are 1, and phase_done and abort_p are 0.
- R2: The "start edge" is a clock edge at which frame_n is 0 and hit is 1, while frame_n was 1 at the previous edge. attn rises after the start edge and stays 1 until the controller returns to idle.
- R3: No transaction starts when hit is 0 at the edge where frame_n is first sampled 0. No transaction starts at a later edge while frame_n stays 0, even if hit becomes 1. attn stays 0 in both cases.
- R4: On a read, loc_rdy sampled 1 at the k-th edge after the start edge, with k from 1 to 15, makes trdy_n 0 after that same edge, which is one clock after loc_rdy was driven.
- R5: On a read, if loc_rdy has not been sampled 1 by the 15th edge after the start edge, stop_n goes 0 after that 15th edge and trdy_n stays 1 for that phase.
- R6: Every data phase after the first is timed from the edge that completed the previous phase. loc_rdy sampled 1 at edge k after it, with k from 1 to 7, gives trdy_n 0 after edge k. If loc_rdy is not seen by edge 7, stop_n goes 0 after edge 7.
- R7: On a write (cmd_wr 1 at the start edge), trdy_n goes 0 after the start edge itself. It stays 0 through the second data phase without any wait. From the third phase onward the R6 timing applies.
- R8: Once stop_n is 0, it stays 0 while frame_n is sampled 0. After the first edge that samples frame_n 1, stop_n and trdy_n are 1 and attn is 0.
- R9: A data phase completes at the first edge after trdy_n went 0. If frame_n is 1 at that edge, the transaction ends: trdy_n returns to 1 and attn to 0 after that edge.
- R10: phase_done is 1 for the one cycle after each completing edge. abort_p is 1 only in the first cycle in which stop_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the local interface |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| hit | input | 1 | Address decode hit for this target |
| cmd_wr | input | 1 | 1 for a write command; sampled at the start edge |
| loc_rdy | input | 1 | Local side ready for the current data phase |
| attn | output | 1 | Transaction in progress, toward the local side |
| trdy_n | output | 1 | Bus TRDY#, active low |
| stop_n | output | 1 | Bus STOP#, active low |
| phase_done | output | 1 | One-cycle pulse after each completed data phase |
| abort_p | output | 1 | One-cycle pulse when a retry or disconnect starts |

## Verification
A wrong latency count shows up at the bus pins as a trdy_n or stop_n edge in the wrong cycle, at most 16 clocks after the fault. Because of this, the scoreboard compares the exact cycle of every output edge instead of only the order of events. A wrong phase index shows up on writes: either a posted phase waits, or the third phase is accepted without loc_rdy. This becomes visible at the next data-phase boundary. A stuck stop or idle state shows up within one clock of frame_n going high, as attn not falling or stop_n not releasing. The bursts in the test mix put phases at both budget limits, so an off-by-one error in either reload value changes a visible edge.

// File: rtl/pci_tmo_pkg.sv
package pci_tmo_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_WAIT = 2'd1,
    TS_XFER = 2'd2,
    TS_STOP = 2'd3
  } tgt_state_e;

  // Value loaded into the latency counter for a phase with the given budget.
  // The last budget clock is used to present TRDY#/STOP# on the bus.
  function automatic int phase_load(input int budget);
    return budget - 1;
  endfunction

  function automatic int larger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Whether the data phase following index idx is accepted with no wait.
  function automatic logic next_is_fast(input logic wr, input int idx, input int nfast);
    return wr && ((idx + 1) < nfast);
  endfunction

endpackage

// File: rtl/tmo_start_det.sv
module tmo_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic hit,
  input  logic idle,
  output logic start
);

  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  // New access: FRAME# low now, high at the previous edge, and decoded for us.
  assign start = idle & ~frame_n & frame_q & hit;

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && $past(!frame_n)) |-> !start);

endmodule

// File: rtl/tmo_latency_timer.sv
module tmo_latency_timer #(
  parameter int CNT_W    = 4,
  parameter int MAX_LOAD = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (load)                    cnt <= load_val;
    else if (run && cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == CNT_W'(1));

  // R6
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_LOAD);

endmodule

// File: rtl/tmo_phase_track.sv
module tmo_phase_track
  import pci_tmo_pkg::*;
#(
  parameter int NFAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  input  logic wr,
  output logic fast_next
);

  localparam int IDX_W = (NFAST < 1) ? 1 : $clog2(NFAST + 1);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(NFAST);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        idx <= '0;
    else if (clear)                    idx <= '0;
    else if (advance && idx != IDX_SAT) idx <= idx + 1'b1;
  end

  assign fast_next = next_is_fast(wr, int'(idx), NFAST);

  // R7
  idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) <= NFAST);

endmodule

// File: rtl/pci_retry_tmo.sv
module pci_retry_tmo
  import pci_tmo_pkg::*;
#(
  parameter int FIRST_BUDGET   = 16,
  parameter int LATER_BUDGET   = 8,
  parameter int FAST_WR_PHASES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic hit,
  input  logic cmd_wr,
  input  logic loc_rdy,
  output logic attn,
  output logic trdy_n,
  output logic stop_n,
  output logic phase_done,
  output logic abort_p
);

  localparam int MAX_BUDGET = larger(FIRST_BUDGET, LATER_BUDGET);
  localparam int CNT_W      = $clog2(MAX_BUDGET);
  localparam logic [CNT_W-1:0] LOAD_FIRST = CNT_W'(phase_load(FIRST_BUDGET));
  localparam logic [CNT_W-1:0] LOAD_LATER = CNT_W'(phase_load(LATER_BUDGET));

  tgt_state_e       state_q, state_d;
  logic             wr_q;
  logic             start;
  logic             t_load, t_run, t_expire;
  logic [CNT_W-1:0] t_load_val;
  logic             ph_clear, ph_adv, fast_next;
  logic             first_fast;
  logic             abort_d;
  logic             pdone_q, abort_q;

  tmo_start_det u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .hit     (hit),
    .idle    (state_q == TS_IDLE),
    .start   (start)
  );

  tmo_latency_timer #(
    .CNT_W    (CNT_W),
    .MAX_LOAD (MAX_BUDGET - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_load_val),
    .run      (t_run),
    .expire   (t_expire)
  );

  tmo_phase_track #(
    .NFAST (FAST_WR_PHASES)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ph_clear),
    .advance   (ph_adv),
    .wr        (wr_q),
    .fast_next (fast_next)
  );

  assign first_fast = next_is_fast(cmd_wr, -1, FAST_WR_PHASES);
  assign t_run      = (state_q == TS_WAIT) && !loc_rdy;

  always_comb begin
    state_d    = state_q;
    t_load     = 1'b0;
    t_load_val = LOAD_FIRST;
    ph_clear   = 1'b0;
    ph_adv     = 1'b0;
    abort_d    = 1'b0;
    case (state_q)
      TS_IDLE: begin
        if (start) begin
          ph_clear = 1'b1;
          t_load   = 1'b1;
          state_d  = first_fast ? TS_XFER : TS_WAIT;
        end
      end
      TS_WAIT: begin
        if (loc_rdy) begin
          state_d = TS_XFER;
        end else if (t_expire) begin
          state_d = TS_STOP;
          abort_d = 1'b1;
        end
      end
      TS_XFER: begin
        if (frame_n) begin
          state_d = TS_IDLE;
        end else begin
          ph_adv = 1'b1;
          if (fast_next) begin
            state_d = TS_XFER;
          end else begin
            state_d    = TS_WAIT;
            t_load     = 1'b1;
            t_load_val = LOAD_LATER;
          end
        end
      end
      TS_STOP: begin
        if (frame_n) state_d = TS_IDLE;
      end
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      wr_q    <= 1'b0;
      pdone_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) wr_q <= cmd_wr;
      pdone_q <= (state_q == TS_XFER);
      abort_q <= abort_d;
    end
  end

  assign attn       = (state_q != TS_IDLE);
  assign trdy_n     = (state_q != TS_XFER);
  assign stop_n     = (state_q != TS_STOP);
  assign phase_done = pdone_q;
  assign abort_p    = abort_q;

  // R2
  attn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn) |-> $past(!frame_n && hit));

  // R4
  trdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> ($past(loc_rdy) || $past(start)));

  // R5
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n) |-> $past(t_expire));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);

  // R9
  normal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && frame_n) |=> (trdy_n && !attn));

  // R10
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> $fell(stop_n));

endmodule

// File: tb/pci_retry_tmo_tb.sv
module pci_retry_tmo_tb;

  localparam int EV_ATTN_R = 0;
  localparam int EV_TRDY_F = 1;
  localparam int EV_STOP_F = 2;
  localparam int EV_ABORT  = 3;
  localparam int EV_PDONE  = 4;
  localparam int EV_STOP_R = 5;
  localparam int EV_ATTN_F = 6;

  localparam int BUD_FIRST = 16;
  localparam int BUD_LATER = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, hit = 1'b0, cmd_wr = 1'b0, loc_rdy = 1'b0;
  logic attn, trdy_n, stop_n, phase_done, abort_p;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int lat_q [0:7];

  int    k_q[$];
  int    c_q[$];
  string r_q[$];

  pci_retry_tmo u_dut (
    .clk (clk), .rst_n (rst_n), .frame_n (frame_n), .hit (hit),
    .cmd_wr (cmd_wr), .loc_rdy (loc_rdy), .attn (attn), .trdy_n (trdy_n),
    .stop_n (stop_n), .phase_done (phase_done), .abort_p (abort_p)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string kind_req(input int k);
    case (k)
      EV_ATTN_R: return "R2";
      EV_TRDY_F: return "R4";
      EV_STOP_F: return "R5";
      EV_ABORT:  return "R10";
      EV_PDONE:  return "R10";
      EV_STOP_R: return "R8";
      default:   return "R9";
    endcase
  endfunction

  task automatic push(input int k, input int c, input string r);
    k_q.push_back(k);
    c_q.push_back(c);
    r_q.push_back(r);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Monitor: pops one expected item for every output event it sees.
  task automatic observe(input int k);
    int ek, ec;
    string er;
    nchk++;
    if (k_q.size() == 0) begin
      nfail++;
      $display("FAIL %s unexpected event: actual kind %0d at cycle %0d expected none",
               kind_req(k), k, cyc);
    end else begin
      ek = k_q.pop_front();
      ec = c_q.pop_front();
      er = r_q.pop_front();
      if (ek != k || ec != cyc) begin
        nfail++;
        $display("FAIL %s event: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 er, k, cyc, ek, ec);
      end
    end
  endtask

  initial begin
    logic pa, pt, ps;
    wait (rst_n);
    @(posedge clk); #3;
    pa = attn; pt = trdy_n; ps = stop_n;
    forever begin
      @(posedge clk); #3;
      if (attn && !pa)   observe(EV_ATTN_R);
      if (!trdy_n && pt) observe(EV_TRDY_F);
      if (!stop_n && ps) observe(EV_STOP_F);
      if (abort_p)       observe(EV_ABORT);
      if (phase_done)    observe(EV_PDONE);
      if (stop_n && !ps) observe(EV_STOP_R);
      if (!attn && pa)   observe(EV_ATTN_F);
      pa = attn; pt = trdy_n; ps = stop_n;
    end
  end

  task automatic check_idle(input string req);
    check(attn == 1'b0,   req, "attn idle",   int'(attn),   0);
    check(trdy_n == 1'b1, req, "trdy_n idle", int'(trdy_n), 1);
    check(stop_n == 1'b1, req, "stop_n idle", int'(stop_n), 1);
  endtask

  // Driver: runs one transaction and queues every output edge it implies.
  task automatic run_txn(input bit wr, input int nph);
    int s, p, c;
    bit dead;
    @(negedge clk);
    frame_n = 1'b0; hit = 1'b1; cmd_wr = wr;
    s = cyc + 1;
    push(EV_ATTN_R, s, "R2");
    if (wr) push(EV_TRDY_F, s, "R7");
    @(negedge clk);
    hit = 1'b0; cmd_wr = 1'b0;
    p = s; dead = 1'b0;
    for (int k = 0; k < nph && !dead; k++) begin
      bit last;
      int bud, lt;
      last = (k == nph - 1);
      bud  = (k == 0) ? BUD_FIRST : BUD_LATER;
      lt   = lat_q[k];
      if (wr && k < 2) begin
        if (last) frame_n = 1'b1;
        c = p + 1;
        push(EV_PDONE, c, "R10");
        if (last) push(EV_ATTN_F, c, "R9");
        @(negedge clk);
        p = c;
      end else if (lt >= 1 && lt <= bud - 1) begin
        while (cyc < p + lt - 1) @(negedge clk);
        loc_rdy = 1'b1;
        push(EV_TRDY_F, p + lt, (k == 0) ? "R4" : "R6");
        @(negedge clk);
        loc_rdy = 1'b0;
        if (last) frame_n = 1'b1;
        c = p + lt + 1;
        push(EV_PDONE, c, "R10");
        if (last) push(EV_ATTN_F, c, "R9");
        @(negedge clk);
        p = c;
      end else begin
        push(EV_STOP_F, p + bud - 1, (k == 0) ? "R5" : "R6");
        push(EV_ABORT,  p + bud - 1, "R10");
        while (cyc < p + bud) @(negedge clk);
        check(stop_n == 1'b0, "R8", "stop_n held", int'(stop_n), 0);
        check(trdy_n == 1'b1, "R5", "no trdy after stop", int'(trdy_n), 1);
        frame_n = 1'b1;
        push(EV_STOP_R, p + bud + 1, "R8");
        push(EV_ATTN_F, p + bud + 1, "R8");
        @(negedge clk);
        dead = 1'b1;
      end
    end
    check_idle("R9");
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) lat_q[i] = 1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    check(phase_done == 1'b0, "R1", "phase_done in reset", int'(phase_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    check(abort_p == 1'b0, "R1", "abort_p after reset", int'(abort_p), 0);

    // R3: miss, then hit arrives mid-transaction
    frame_n = 1'b0; hit = 1'b0;
    repeat (3) @(negedge clk);
    check(attn == 1'b0, "R3", "attn on decode miss", int'(attn), 0);
    hit = 1'b1;
    repeat (3) @(negedge clk);
    check(attn == 1'b0, "R3", "attn on late hit", int'(attn), 0);
    frame_n = 1'b1; hit = 1'b0;
    repeat (2) @(negedge clk);

    // reads
    lat_q[0] = 1;  run_txn(1'b0, 1);
    lat_q[0] = 15; run_txn(1'b0, 1);
    lat_q[0] = 0;  run_txn(1'b0, 1);
    lat_q[0] = 4; lat_q[1] = 7; lat_q[2] = 2; run_txn(1'b0, 3);
    lat_q[0] = 3; lat_q[1] = 0; run_txn(1'b0, 2);

    // writes
    run_txn(1'b1, 1);
    run_txn(1'b1, 2);
    lat_q[2] = 7; lat_q[3] = 1; run_txn(1'b1, 4);
    lat_q[2] = 0; run_txn(1'b1, 3);

    repeat (4) @(negedge clk);
    while (k_q.size() > 0) begin
      nchk++; nfail++;
      $display("FAIL %s missing event: actual none expected kind %0d cycle %0d",
               r_q[0], k_q[0], c_q[0]);
      void'(k_q.pop_front()); void'(c_q.pop_front()); void'(r_q.pop_front());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

endmodule